// File: doc/BRIEF.md
# Programmable BCD Feedback Divider

This block divides a prescaled clock inside the feedback path of a phase-locked loop. It gives one output pulse for every N input clocks. N is set by a single BCD digit d and equals 29 − d, so digits 0 through 9 give ratios from 29 down to 20. Behind a fixed divide-by-ten prescaler, the loop therefore sees overall ratios of 200 to 290 in steps of ten. With a 500 kHz comparison frequency, that places the oscillator between 100 and 145 MHz in 5 MHz steps.

Each cycle starts by loading two cascaded decade counters. The low decade takes the digit and the high decade takes zero. The counters then count up to a fixed terminal state of 25. A decode of that state arms a two-flop tail. The tail raises the output two clocks later, holds the counters in their preset for two clocks, and then releases them. The digit is written in two halves by two load strobes. The strobe for the upper half also captures two band-select bits, which go straight to an output.

Top module: `bcd_fb_divider`

## Requirements
- R1: With an effective digit d, rising edges of `div_out` are exactly 29 − d clocks apart: 29 for d = 0, 20 for d = 9.
- R2: In every period, `div_out` stays high for exactly 2 clocks.
- R3: A stored digit code from 10 to 15 behaves as digit 9, giving a period of 20 clocks.
- R4: A clock edge with `ld_lo` high stores `prog_digit[1:0]` into the low half of the digit. A clock edge with `ld_hi` high stores `prog_digit[3:2]` into the high half. Either strobe alone leaves the other half unchanged.
- R5: A clock edge with `ld_hi` high stores `band_in`, and the stored value appears on `band_out` after that edge. `band_out` does not change on a cycle where `ld_hi` is low, including when only `ld_lo` strobes.
- R6: A digit written while the counters are counting does not change the period already in progress. The first interval between rising edges after that write keeps the old ratio, and the next interval uses the new one.
- R7: While `rst` is high at a clock edge, `div_out` goes low, `band_out` clears, and the stored digit becomes 0. After `rst` is released, the first rise of `div_out` comes on the 27th clock edge, and the period is then 29.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled clock that the counters divide |
| rst | input | 1 | Synchronous reset, active high |
| prog_digit | input | 4 | BCD programming digit |
| ld_lo | input | 1 | Load strobe for digit bits 1:0 |
| ld_hi | input | 1 | Load strobe for digit bits 3:2 and the band bits |
| band_in | input | 2 | Band-select bits to latch |
| band_out | output | 2 | Latched band-select bits |
| div_out | output | 1 | Divided output pulse |

## Verification
The assertions check several things on every cycle. They check the two-clock high time of the output and that the low time at each rise lies within the 20 to 29 ratio range. They check the capture of the band bits and that those bits hold between strobes, and they check the reset state. Only the bench scenarios can show the exact period for a given digit and the split two-half digit write. They also show the clamp of non-BCD codes, the moment a new digit takes effect relative to a cycle in progress, and the latency of the first pulse after reset.

// File: rtl/bcdiv_pkg.sv
package bcdiv_pkg;

   localparam int BCD_W = 4;

   // decimal digit at position pos (0 = units) of a non-negative value
   function automatic int dec_digit(input int value, input int pos);
      int v;
      v = value;
      for (int i = 0; i < pos; i++) v = v / 10;
      return v % 10;
   endfunction

   function automatic int pow10(input int n);
      int r;
      r = 1;
      for (int i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction

endpackage

// File: rtl/bcdiv_prog_latch.sv
module bcdiv_prog_latch #(
   parameter int DIG_W     = 4,
   parameter int LO_W      = 2,
   parameter int BAND_W    = 2,
   parameter int MAX_DIGIT = 9,
   parameter bit CLAMP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [DIG_W-1:0]  digit_in,
   input  logic [BAND_W-1:0] band_in,
   output logic [DIG_W-1:0]  digit_eff,
   output logic [BAND_W-1:0] band_q
);

   localparam logic [DIG_W-1:0] MAX_V = DIG_W'(MAX_DIGIT);

   logic [DIG_W-1:0] dig_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dig_q  <= '0;
         band_q <= '0;
      end else begin
         if (ld_lo) dig_q[LO_W-1:0] <= digit_in[LO_W-1:0];
         if (ld_hi) begin
            dig_q[DIG_W-1:LO_W] <= digit_in[DIG_W-1:LO_W];
            band_q              <= band_in;
         end
      end
   end

   // clamp at the point of use so the ratio never drops below its minimum
   generate
      if (CLAMP_EN) begin : g_clamp
         assign digit_eff = (dig_q > MAX_V) ? MAX_V : dig_q;
      end else begin : g_raw
         assign digit_eff = dig_q;
      end
   endgenerate

endmodule

// File: rtl/bcdiv_decade_chain.sv
module bcdiv_decade_chain #(
   parameter int NDEC   = 2,
   parameter int DEC_AT = 25
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       load,
   input  logic [bcdiv_pkg::BCD_W-1:0] preset,
   output logic                       term
);

   localparam int W = bcdiv_pkg::BCD_W;

   logic [NDEC-1:0] carry;
   logic [NDEC-1:0] match;

   assign carry[0] = 1'b1;

   generate
      for (genvar gi = 0; gi < NDEC; gi++) begin : g_dec
         localparam logic [W-1:0] TGT = W'(bcdiv_pkg::dec_digit(DEC_AT, gi));
         logic [W-1:0] q;

         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (load)
               q <= (gi == 0) ? preset : '0;
            else if (carry[gi])
               q <= (q == W'(9)) ? '0 : q + W'(1);
         end

         if (gi < NDEC - 1) begin : g_carry
            assign carry[gi+1] = carry[gi] && (q == W'(9));
         end

         assign match[gi] = (q == TGT);
      end
   endgenerate

   assign term = &match;

endmodule

// File: rtl/bcdiv_tail_seq.sv
module bcdiv_tail_seq (
   input  logic clk,
   input  logic rst,
   input  logic term,
   output logic pulse
);

   // arm_q follows the decode; pulse_q then runs for two clocks
   logic arm_q;
   logic pulse_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         arm_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (term)         arm_q <= 1'b1;
         else if (pulse_q) arm_q <= 1'b0;

         if (arm_q && !pulse_q)      pulse_q <= 1'b1;
         else if (pulse_q && !arm_q) pulse_q <= 1'b0;
      end
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/bcd_fb_divider.sv
module bcd_fb_divider #(
   parameter int DIG_W     = 4,
   parameter int LO_W      = 2,
   parameter int BAND_W    = 2,
   parameter int NDEC      = 2,
   parameter int DEC_AT    = 25,
   parameter int MAX_DIGIT = 9,
   parameter bit CLAMP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIG_W-1:0]  prog_digit,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [BAND_W-1:0] band_in,
   output logic [BAND_W-1:0] band_out,
   output logic              div_out
);

   generate
      if (DIG_W != bcdiv_pkg::BCD_W) begin : g_bad_width
         $error("digit width must be one BCD nibble");
      end
      if (LO_W < 1 || LO_W >= DIG_W) begin : g_bad_split
         $error("low half must leave bits for the high half");
      end
      if (MAX_DIGIT < 0 || MAX_DIGIT > 9) begin : g_bad_max
         $error("clamp digit must be a BCD digit");
      end
      if (DEC_AT <= MAX_DIGIT || DEC_AT + 2 >= bcdiv_pkg::pow10(NDEC)) begin : g_bad_term
         $error("terminal state must sit above every preset and fit the decades");
      end
   endgenerate

   logic [DIG_W-1:0] digit_eff;
   logic             term;
   logic             pulse;

   bcdiv_prog_latch #(
      .DIG_W    (DIG_W),
      .LO_W     (LO_W),
      .BAND_W   (BAND_W),
      .MAX_DIGIT(MAX_DIGIT),
      .CLAMP_EN (CLAMP_EN)
   ) u_latch (
      .clk      (clk),
      .rst      (rst),
      .ld_lo    (ld_lo),
      .ld_hi    (ld_hi),
      .digit_in (prog_digit),
      .band_in  (band_in),
      .digit_eff(digit_eff),
      .band_q   (band_out)
   );

   // counters sit in their preset for as long as the pulse is high
   bcdiv_decade_chain #(
      .NDEC  (NDEC),
      .DEC_AT(DEC_AT)
   ) u_chain (
      .clk   (clk),
      .rst   (rst),
      .load  (pulse),
      .preset(digit_eff),
      .term  (term)
   );

   bcdiv_tail_seq u_tail (
      .clk  (clk),
      .rst  (rst),
      .term (term),
      .pulse(pulse)
   );

   assign div_out = pulse;

endmodule

// File: rtl/bcdiv_checker.sv
module bcdiv_checker #(
   parameter int DEC_AT    = 25,
   parameter int MAX_DIGIT = 9,
   parameter int BAND_W    = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              ld_hi,
   input logic [BAND_W-1:0] band_in,
   input logic [BAND_W-1:0] band_out,
   input logic              div_out
);

   localparam int MIN_LOW = DEC_AT + 2 - MAX_DIGIT;
   localparam int MAX_LOW = DEC_AT + 2;

   logic [7:0] low_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         low_cnt <= '0;
      else if (div_out)
         low_cnt <= '0;
      else if (low_cnt != 8'hff)
         low_cnt <= low_cnt + 8'd1;
   end

   // R1: low time before every rise keeps the ratio within its range
   p_ratio_range_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(div_out) |-> (int'(low_cnt) >= MIN_LOW && int'(low_cnt) <= MAX_LOW));

   // R2: two-clock high time
   p_high_first_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(div_out) |=> div_out);

   p_high_end_r2: assert property (@(posedge clk) disable iff (rst)
      (div_out && $past(div_out)) |=> !div_out);

   // R5: band capture and hold
   p_band_load_r5: assert property (@(posedge clk) disable iff (rst)
      ld_hi |=> (band_out == $past(band_in)));

   p_band_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !ld_hi |=> $stable(band_out));

   // R7: reset state
   p_reset_state_r7: assert property (@(posedge clk)
      rst |=> (!div_out && band_out == '0));

endmodule

bind bcd_fb_divider bcdiv_checker #(
   .DEC_AT   (DEC_AT),
   .MAX_DIGIT(MAX_DIGIT),
   .BAND_W   (BAND_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .ld_hi   (ld_hi),
   .band_in (band_in),
   .band_out(band_out),
   .div_out (div_out)
);

// File: tb/bcd_fb_divider_test.sv
module bcd_fb_divider_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] prog_digit = '0;
   logic       ld_lo = 1'b0;
   logic       ld_hi = 1'b0;
   logic [1:0] band_in = '0;
   logic [1:0] band_out;
   logic       div_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   int cyc = 0;
   int rise_cnt = 0;
   int last_rise = 0;
   int last_period = 0;
   bit prev_out = 1'b0;

   always #5 clk = ~clk;

   bcd_fb_divider uut (
      .clk       (clk),
      .rst       (rst),
      .prog_digit(prog_digit),
      .ld_lo     (ld_lo),
      .ld_hi     (ld_hi),
      .band_in   (band_in),
      .band_out  (band_out),
      .div_out   (div_out)
   );

   function automatic int exp_ratio(input int code);
      return 29 - ((code > 9) ? 9 : code);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor samples one time unit after each rising edge
   always @(posedge clk) begin
      #1;
      cyc++;
      if (rst) begin
         prev_out = 1'b0;
      end else begin
         if (div_out && !prev_out) begin
            if (rise_cnt > 0) last_period = cyc - last_rise;
            last_rise = cyc;
            rise_cnt++;
         end
         if (!div_out && prev_out)
            check((cyc - last_rise) == 2, "R2 high time", cyc - last_rise, 2);
         prev_out = div_out;
      end
   end

   task automatic wait_rise();
      int n;
      n = rise_cnt;
      do @(negedge clk); while (rise_cnt == n);
   endtask

   task automatic write(input logic [3:0] d, input logic [1:0] b, input bit lo, input bit hi);
      @(negedge clk);
      prog_digit = d;
      band_in    = b;
      ld_lo      = lo;
      ld_hi      = hi;
      @(negedge clk);
      ld_lo = 1'b0;
      ld_hi = 1'b0;
   endtask

   task automatic settle_and_measure(input int code, input string req);
      wait_rise();
      wait_rise();
      check(last_period == exp_ratio(code), req, last_period, exp_ratio(code));
   endtask

   initial begin
      int c0;
      void'($urandom(32'd4711));

      // R7: reset state and first-pulse latency
      repeat (3) @(negedge clk);
      check(div_out == 1'b0, "R7 reset output", int'(div_out), 0);
      check(band_out == 2'b00, "R7 reset band", int'(band_out), 0);
      rst = 1'b0;
      c0 = cyc;
      wait_rise();
      check((last_rise - c0) == 27, "R7 first rise latency", last_rise - c0, 27);
      wait_rise();
      check(last_period == 29, "R7 digit zero after reset", last_period, 29);

      // R1: every BCD digit
      for (int d = 0; d < 10; d++) begin
         write(4'(d), 2'b00, 1'b1, 1'b1);
         settle_and_measure(d, "R1 ratio per digit");
      end

      // R3: non-BCD codes clamp to nine
      write(4'd12, 2'b00, 1'b1, 1'b1);
      settle_and_measure(12, "R3 clamp code 12");
      write(4'd15, 2'b00, 1'b1, 1'b1);
      settle_and_measure(15, "R3 clamp code 15");

      // R4: halves written separately (5 -> low half 2'b10 gives 6 -> high half 2'b10 gives 10)
      write(4'd5, 2'b01, 1'b1, 1'b1);
      settle_and_measure(5, "R4 full write");
      write(4'b1110, 2'b10, 1'b1, 1'b0);
      settle_and_measure(6, "R4 low half only");
      check(band_out == 2'b01, "R5 band held on low strobe", int'(band_out), 1);
      write(4'b1000, 2'b11, 1'b0, 1'b1);
      settle_and_measure(10, "R4 high half only");

      // R5: band capture visible after the strobe edge
      write(4'd10, 2'b10, 1'b0, 1'b1);
      check(band_out == 2'b10, "R5 band capture", int'(band_out), 2);
      write(4'd0, 2'b01, 1'b0, 1'b0);
      check(band_out == 2'b10, "R5 band unchanged without strobe", int'(band_out), 2);

      // R6: digit change inside a running cycle
      write(4'd0, 2'b00, 1'b1, 1'b1);
      wait_rise();
      wait_rise();
      for (int k = 0; k < 4; k++) begin
         int oldd;
         int newd;
         int dly;
         oldd = (k == 0) ? 0 : (k == 1) ? 9 : (k == 2) ? 3 : 7;
         newd = (k == 0) ? 9 : (k == 1) ? 3 : (k == 2) ? 7 : 1;
         dly  = 3 + int'($urandom_range(0, 12));
         wait_rise();
         repeat (dly) @(negedge clk);
         write(4'(newd), 2'b00, 1'b1, 1'b1);
         wait_rise();
         check(last_period == exp_ratio(oldd), "R6 running period kept", last_period, exp_ratio(oldd));
         wait_rise();
         check(last_period == exp_ratio(newd), "R6 new digit next period", last_period, exp_ratio(newd));
      end

      // constrained random codes and bands
      for (int i = 0; i < 12; i++) begin
         int code;
         logic [1:0] bb;
         code = int'($urandom_range(0, 15));
         bb   = 2'($urandom_range(0, 3));
         write(4'(code), bb, 1'b1, 1'b1);
         check(band_out == bb, "R5 random band", int'(band_out), int'(bb));
         settle_and_measure(code, (code > 9) ? "R3 random code" : "R1 random digit");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule